// File: doc/BRIEF.md
# Dual-Compare Toggle Output Unit

This unit drives one waveform pin from two compare slots that watch a shared, externally supplied timer count. When compare operation is running and the timer advances to a value held in either slot, the pin inverts. If both slots hold the same value and match on the same advance, the pin inverts once. Each slot has its own sticky match flag, and an interrupt line is raised for any flag whose interrupt enable is set.

Software programs the unit through a single-cycle write port. The slot values may be rewritten at any time. A control word carries the run bit, the start level, the interrupt enables and the flag-keep bits. The start level takes effect only while the unit is stopped: a control write in that state also drives the pin to the new level. While the unit runs, the start-level field of any control write is discarded. When the unit is stopped, the pin keeps the level it had at that moment. The start level is also brought out on a port so that the lock can be observed.

Top module: `dual_cmp_toggle`

## Requirements
- R1: A synchronous active-high reset clears both compare values, the run bit, the start level, the interrupt enables and both flags, and drives the pin, `start_level`, `match_flags` and `irq` to 0.
- R2: A write to address 0 loads slot 0 and a write to address 1 loads slot 1, at any time. A timer advance in the same cycle as the write compares against the old value, and the new value applies from the next advance.
- R3: While running, a timer advance whose count equals either slot's value inverts `wave_out` in the following cycle.
- R4: Matches are evaluated only in cycles where `tmr_tick` is 1. A count held for several cycles without a tick causes no further inversion.
- R5: When both slots match on the same advance, `wave_out` inverts exactly once and both flags are set.
- R6: A control write (address 2) while stopped loads the start level from data bit 1, and `wave_out` takes that level in the next cycle. Data bit 0 is the run bit.
- R7: While running, the start-level bit of a control write is ignored. This includes the write that stops the unit, so `start_level` keeps its value.
- R8: After stopping, `wave_out` holds its level. While stopped, ticks whose count matches a slot neither invert the pin nor set a flag.
- R9: Match flags (`match_flags[i]` for slot i) are sticky. A control write with keep bit 4+i at 0 clears flag i, and a match in the same cycle wins over the clear.
- R10: `irq` is 1 whenever some flag i is set and its interrupt enable, control data bit 2+i, is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tmr_cnt | input | CNT_W | Shared timer count |
| tmr_tick | input | 1 | Timer advanced this cycle |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | 0..NUM_CMP-1 slots, NUM_CMP control |
| wr_data | input | CNT_W | Write data |
| wave_out | output | 1 | Waveform pin |
| start_level | output | 1 | Current start-level setting |
| match_flags | output | NUM_CMP | Sticky match flag per slot |
| irq | output | 1 | Interrupt request |

## Verification
The bench places equal values in both slots and checks that the pin flips once rather than twice. A design that summed the matches would leave the pin unchanged and would be caught. It writes a start level of 0 while the unit runs and again in the stopping write; a design without the lock would show `start_level` at 0. It holds a matching count with the tick low and checks the pin is steady, which exposes level-based matching that toggles every clock. It also rewrites a slot in the same cycle as a tick on the slot's old value, and clears a flag in the same cycle as a match. A design that applied the new value early, or let the clear win, would miss the inversion or lose the flag.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Control word field positions (compare slots occupy addresses 0..N-1,
  // the control word sits at address N).
  localparam int unsigned F_RUN = 0;
  localparam int unsigned F_LVL = 1;
  localparam int unsigned F_IE0 = 2;

  function automatic int unsigned keep_pos(input int unsigned n_cmp,
                                           input int unsigned idx);
    return F_IE0 + n_cmp + idx;
  endfunction

  // Count comparison, widened so any CNT_W up to 32 shares one function.
  function automatic logic counts_equal(input logic [31:0] a,
                                        input logic [31:0] b);
    return a == b;
  endfunction

  // Sticky flag update: a match wins over a clear in the same cycle.
  function automatic logic flag_next(input logic cur, input logic hit,
                                     input logic clr);
    return hit | (cur & ~clr);
  endfunction

  // Pin update: an inversion (any number of coincident matches) or a load
  // of the start level while stopped, otherwise hold.
  function automatic logic pin_next(input logic cur, input logic any_hit,
                                    input logic load, input logic lvl);
    logic r;
    if (any_hit)   r = ~cur;
    else if (load) r = lvl;
    else           r = cur;
    return r;
  endfunction

endpackage

// File: rtl/dct_cmp_slot.sv
module dct_cmp_slot
  import dct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             tick,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  output logic             hit
);

  logic [CNT_W-1:0] value_q;

  always_ff @(posedge clk) begin
    if (rst)         value_q <= '0;
    else if (wr_sel) value_q <= wr_val;
  end

  // Compares against the value held before this cycle's write.
  assign hit = tick & run & counts_equal(32'(cnt), 32'(value_q));

endmodule

// File: rtl/dct_flag_bank.sv
module dct_flag_bank
  import dct_pkg::*;
#(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] hit,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] ie,
  output logic [N-1:0] flags,
  output logic         irq
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) flags[i] <= 1'b0;
      else     flags[i] <= flag_next(flags[i], hit[i], clr[i]);
    end
  end

  assign irq = |(flags & ie);

endmodule

// File: rtl/dct_wave_core.sv
module dct_wave_core
  import dct_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic any_hit,
  input  logic load_en,
  input  logic load_lvl,
  output logic wave
);

  always_ff @(posedge clk) begin
    if (rst) wave <= 1'b0;
    else     wave <= pin_next(wave, any_hit, load_en, load_lvl);
  end

endmodule

// File: rtl/dual_cmp_toggle.sv
module dual_cmp_toggle
  import dct_pkg::*;
#(
  parameter  int CNT_W   = 16,
  parameter  int NUM_CMP = 2,
  localparam int ADDR_W  = $clog2(NUM_CMP + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   tmr_cnt,
  input  logic               tmr_tick,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic               wave_out,
  output logic               start_level,
  output logic [NUM_CMP-1:0] match_flags,
  output logic               irq
);

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_CMP);

  logic               run_q;
  logic               lvl_q;
  logic [NUM_CMP-1:0] ie_q;
  logic [NUM_CMP-1:0] hit_vec;
  logic [NUM_CMP-1:0] flag_clr;
  logic               ctrl_wr;
  logic               load_en;
  logic               any_hit;

  assign ctrl_wr = wr_en && (wr_addr == CTRL_ADDR);
  assign load_en = ctrl_wr & ~run_q;   // start level writable only when stopped
  assign any_hit = |hit_vec;           // coincident matches merge into one flip

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      lvl_q <= 1'b0;
      ie_q  <= '0;
    end else if (ctrl_wr) begin
      run_q <= wr_data[F_RUN];
      ie_q  <= wr_data[F_IE0 +: NUM_CMP];
      if (!run_q) lvl_q <= wr_data[F_LVL];
    end
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_slot
    dct_cmp_slot #(.CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst    (rst),
      .wr_sel (wr_en && (wr_addr == ADDR_W'(i))),
      .wr_val (wr_data),
      .tick   (tmr_tick),
      .run    (run_q),
      .cnt    (tmr_cnt),
      .hit    (hit_vec[i])
    );
    assign flag_clr[i] = ctrl_wr & ~wr_data[keep_pos(NUM_CMP, i)];
  end

  dct_flag_bank #(.N(NUM_CMP)) u_flags (
    .clk   (clk),
    .rst   (rst),
    .hit   (hit_vec),
    .clr   (flag_clr),
    .ie    (ie_q),
    .flags (match_flags),
    .irq   (irq)
  );

  dct_wave_core u_wave (
    .clk      (clk),
    .rst      (rst),
    .any_hit  (any_hit),
    .load_en  (load_en),
    .load_lvl (wr_data[F_LVL]),
    .wave     (wave_out)
  );

  assign start_level = lvl_q;

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int N = 2
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic         run,
  input logic         ctrl_wr,
  input logic         load_en,
  input logic [N-1:0] hit,
  input logic [N-1:0] clr,
  input logic [N-1:0] ie,
  input logic [N-1:0] flags,
  input logic         wave,
  input logic         level,
  input logic         irq
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (wave == 1'b0 && flags == '0 && level == 1'b0 && irq == 1'b0));

  a_r3_flip_on_match: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> (wave != $past(wave)));

  a_r4_match_needs_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |-> (hit == '0));

  a_r8_idle_ignores_count: assert property (@(posedge clk) disable iff (rst)
    !run |-> (hit == '0));

  a_r8_pin_holds: assert property (@(posedge clk) disable iff (rst)
    (!(|hit) && !load_en) |=> $stable(wave));

  a_r7_level_locked: assert property (@(posedge clk) disable iff (rst)
    (run && ctrl_wr) |=> $stable(level));

  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~clr) != '0) |=>
      ((flags & $past(flags & ~clr)) == $past(flags & ~clr)));

  a_r9_match_sets_flag: assert property (@(posedge clk) disable iff (rst)
    (|hit) |=> ((flags & $past(hit)) == $past(hit)));

  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (rst)
    irq == |(flags & ie));

endmodule

bind dual_cmp_toggle dct_checker #(.N(NUM_CMP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tmr_tick),
  .run     (run_q),
  .ctrl_wr (ctrl_wr),
  .load_en (load_en),
  .hit     (hit_vec),
  .clr     (flag_clr),
  .ie      (ie_q),
  .flags   (match_flags),
  .wave    (wave_out),
  .level   (start_level),
  .irq     (irq)
);

// File: tb/dual_cmp_toggle_bench.sv
`timescale 1ns/1ps
module dual_cmp_toggle_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] tmr_cnt;
  logic        tmr_tick;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic        wave_out;
  logic        start_level;
  logic [1:0]  match_flags;
  logic        irq;

  always #10 clk = ~clk;   // 50 MHz

  dual_cmp_toggle u_dual_cmp_toggle (
    .clk(clk), .rst(rst), .tmr_cnt(tmr_cnt), .tmr_tick(tmr_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wave_out(wave_out), .start_level(start_level),
    .match_flags(match_flags), .irq(irq)
  );

  typedef struct {
    logic       wave;
    logic       lvl;
    logic [1:0] flags;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Reference state, written from the requirements.
  logic        m_wave, m_lvl, m_run;
  logic [1:0]  m_flag, m_ie;
  logic [15:0] m_cmp [2];

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ctl(input logic run, input logic lvl,
                                      input logic [1:0] ie,
                                      input logic [1:0] keep);
    return {10'd0, keep, ie, lvl, run};
  endfunction

  // Driver: drives one cycle of stimulus and pushes the expected outputs.
  task automatic step(input logic w, input logic [1:0] a,
                      input logic [15:0] d, input logic tk,
                      input logic [15:0] c, input string tag);
    exp_t e;
    logic [1:0] hit;
    logic cw;
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; tmr_tick = tk; tmr_cnt = c;
    cw = w && (a == 2'd2);
    for (int i = 0; i < 2; i++) hit[i] = tk && m_run && (c == m_cmp[i]);
    if (|hit)             m_wave = ~m_wave;
    else if (cw && !m_run) m_wave = d[1];
    if (cw && !m_run) m_lvl = d[1];
    for (int i = 0; i < 2; i++)
      m_flag[i] = hit[i] | (m_flag[i] & ~(cw & ~d[4+i]));
    if (w && a == 2'd0) m_cmp[0] = d;
    if (w && a == 2'd1) m_cmp[1] = d;
    if (cw) begin m_run = d[0]; m_ie = d[3:2]; end
    e.wave = m_wave; e.lvl = m_lvl; e.flags = m_flag;
    e.irq = |(m_flag & m_ie); e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares outputs after each active edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #5;
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "wave_out",    16'(wave_out),    16'(e.wave));
        chk(e.tag, "start_level", 16'(start_level), 16'(e.lvl));
        chk(e.tag, "match_flags", 16'(match_flags), 16'(e.flags));
        chk(e.tag, "irq",         16'(irq),         16'(e.irq));
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; tmr_tick = 0; tmr_cnt = 0;
    m_wave = 0; m_lvl = 0; m_run = 0; m_flag = 0; m_ie = 0;
    m_cmp[0] = 0; m_cmp[1] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "wave_out",    16'(wave_out),    16'd0);
    chk("R1", "start_level", 16'(start_level), 16'd0);
    chk("R1", "match_flags", 16'(match_flags), 16'd0);
    chk("R1", "irq",         16'(irq),         16'd0);
    rst = 1'b0;

    step(1, 2'd0, 16'd5, 0, 0, "R2");
    step(1, 2'd1, 16'd9, 0, 0, "R2");
    step(1, 2'd2, ctl(0, 1, 2'b00, 2'b11), 0, 0, "R6");   // pin -> 1
    step(1, 2'd2, ctl(1, 1, 2'b00, 2'b11), 0, 0, "R6");   // run
    for (int c = 0; c <= 11; c++) step(0, 0, 0, 1, 16'(c), "R3");
    repeat (3) step(0, 0, 0, 0, 16'd9, "R4");             // held count, no tick
    step(1, 2'd2, ctl(1, 0, 2'b00, 2'b11), 0, 0, "R7");   // level ignored
    step(1, 2'd2, ctl(0, 0, 2'b00, 2'b11), 0, 0, "R7");   // stop, level ignored
    step(0, 0, 0, 1, 16'd5, "R8");                        // stopped: no flip
    step(0, 0, 0, 1, 16'd9, "R8");
    step(1, 2'd2, ctl(0, 0, 2'b11, 2'b00), 0, 0, "R9");   // clear flags, pin -> 0
    step(1, 2'd0, 16'd20, 0, 0, "R5");
    step(1, 2'd1, 16'd20, 0, 0, "R5");
    step(1, 2'd2, ctl(1, 0, 2'b11, 2'b11), 0, 0, "R5");
    step(0, 0, 0, 1, 16'd20, "R5");                       // one flip, both flags
    step(0, 0, 0, 1, 16'd21, "R5");
    step(1, 2'd2, ctl(1, 0, 2'b11, 2'b10), 0, 0, "R10");  // clear flag0 only
    step(1, 2'd2, ctl(1, 0, 2'b01, 2'b11), 0, 0, "R10");  // ie1 off -> irq 0
    step(1, 2'd2, ctl(1, 0, 2'b11, 2'b11), 0, 0, "R10");  // ie1 on -> irq 1
    step(1, 2'd1, 16'd40, 0, 0, "R2");
    step(1, 2'd0, 16'd30, 1, 16'd20, "R2");               // old value still hits
    step(0, 0, 0, 1, 16'd20, "R2");                       // no longer hits
    step(0, 0, 0, 1, 16'd30, "R2");                       // new value hits
    step(1, 2'd2, ctl(1, 0, 2'b11, 2'b00), 1, 16'd30, "R9"); // set beats clear
    step(0, 0, 0, 1, 16'd40, "R3");
    step(0, 0, 0, 0, 0, "R8");
    repeat (3) @(posedge clk);
    #6;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule